// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block is the configuration front end of a multi-function peripheral controller. Software reaches it through two byte-wide I/O locations: an index location that picks a register and a data location that reads or writes the picked register. The register file stays locked until a two-byte key is written to the index location in two consecutive accesses. A dedicated exit byte locks it again. While it is locked, data accesses have no effect and reads return all ones.

Once the port is unlocked, a device-number register selects one bank among the implemented logical devices. Each bank holds an enable flag, a 16-bit I/O base, two interrupt numbers, a DMA channel and a few device-specific mode bytes. The block drives these values out as flat vectors so that the peripheral functions can use them. It also holds global registers for a bank-wide soft reset and for two power-down controls.

Top module: `kcfg_port`

## Requirements
- R1: After reset the port is locked (`cfg_open` = 0), `rdata` reads 0xFF, and the enable, base, interrupt, DMA and mode outputs of every device are zero. The power-down outputs are also zero.
- R2: The port unlocks only when an index write (`addr` = 0) of 0x51 is followed by an index write of 0x23, with no other write between them. A second 0x51 keeps the detector waiting for 0x23. Any other index byte returns the detector to idle, and so does any data write (`addr` = 1).
- R3: An index write of 0xBB while unlocked locks the port in the next cycle. While the port is locked, data writes change no register or output, and `rdata` is 0xFF.
- R4: While unlocked, index 0x07 reads and writes the device number, which selects the bank for every index of 0x30 or above. The implemented device numbers are 0, 3, 4, 5, 6, 7 and 8, driven on output slots 0 to 6 in that order.
- R5: In the selected bank, index 0x30 bit 0 is the enable flag (other bits read 0). Index 0x60 is the upper byte and 0x61 the lower byte of the I/O base. Index 0x70 is the primary interrupt, 0x72 the secondary interrupt and 0x74 the DMA channel. Each one drives the matching output one cycle after the write.
- R6: Each bank has four mode bytes at indexes 0xF0 to 0xF3. Slot s drives byte m on `dev_mode[(s*4+m)*8 +: 8]`.
- R7: When the device number names no implemented device, bank indexes read 0xFF and writes to them change nothing. Any index that is not implemented also reads 0xFF.
- R8: A data write to index 0x02 with bit 0 set clears every bank register of every device in the next cycle. The device number and the power registers keep their values. Index 0x02 reads 0x00, and a write to it with bit 0 clear has no effect.
- R9: Index 0x22 (direct power-down) and index 0x23 (automatic power-down) are full bytes that can be read back and drive `pd_direct` and `pd_auto`.
- R10: A write to one bank leaves the registers of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| addr | input | 1 | 0 selects the index location, 1 selects the data location |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Data-location read value for the current index |
| cfg_open | output | 1 | Configuration mode is unlocked |
| dev_active | output | NUM_DEV | Enable flag per device slot |
| dev_base | output | NUM_DEV*16 | I/O base per slot |
| dev_irq | output | NUM_DEV*8 | Primary interrupt per slot |
| dev_irq2 | output | NUM_DEV*8 | Secondary interrupt per slot |
| dev_dma | output | NUM_DEV*8 | DMA channel per slot |
| dev_mode | output | NUM_DEV*MODE_REGS*8 | Mode bytes per slot |
| pd_direct | output | 8 | Direct power-down control |
| pd_auto | output | 8 | Automatic power-down control |

## Verification
The assertions assume at most one access per cycle and treat a write as a single-cycle `wr_en` pulse whose `addr` and `wdata` are valid in that cycle. No reads have side effects, so `rdata` is only checked as a combinational value of the current state. The stimulus drives each write for exactly one clock, starting on the falling edge. Random index choices come from a set that covers implemented, unimplemented and key or exit bytes. Random device numbers include unimplemented values. Key sequences, interrupted keys and exits are mixed in so that the locked-state checks also run.

// File: rtl/kcfg_pkg.sv
package kcfg_pkg;

    localparam logic [7:0] KEY_FIRST   = 8'h51;
    localparam logic [7:0] KEY_SECOND  = 8'h23;
    localparam logic [7:0] KEY_EXIT    = 8'hBB;

    localparam logic [7:0] IDX_SRST    = 8'h02;
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_PD_DIR  = 8'h22;
    localparam logic [7:0] IDX_PD_AUTO = 8'h23;
    localparam logic [7:0] IDX_BANK_LO = 8'h30;

    localparam logic [7:0] OFS_ACT     = 8'h30;
    localparam logic [7:0] OFS_BASE_HI = 8'h60;
    localparam logic [7:0] OFS_BASE_LO = 8'h61;
    localparam logic [7:0] OFS_IRQ     = 8'h70;
    localparam logic [7:0] OFS_IRQ2    = 8'h72;
    localparam logic [7:0] OFS_DMA     = 8'h74;
    localparam logic [7:0] OFS_MODE    = 8'hF0;

    localparam logic [7:0] RD_NONE     = 8'hFF;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_KEY1   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;

    // Device number carried by each output slot
    function automatic logic [7:0] slot_ldn(input int slot);
        case (slot)
            0:       slot_ldn = 8'd0;
            1:       slot_ldn = 8'd3;
            2:       slot_ldn = 8'd4;
            3:       slot_ldn = 8'd5;
            4:       slot_ldn = 8'd6;
            5:       slot_ldn = 8'd7;
            6:       slot_ldn = 8'd8;
            default: slot_ldn = 8'(slot + 2);
        endcase
    endfunction

endpackage

// File: rtl/kcfg_unlock.sv
module kcfg_unlock
    import kcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    output logic       open,
    output logic       idx_load
);

    typedef struct packed {
        key_state_e ks;
    } unlock_t;

    unlock_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        idx_load = 1'b0;
        case (st_q.ks)
            KS_LOCKED: begin
                if (idx_wr && wdata == KEY_FIRST) st_d.ks = KS_KEY1;
            end
            KS_KEY1: begin
                if (dat_wr) begin
                    st_d.ks = KS_LOCKED;
                end else if (idx_wr) begin
                    if (wdata == KEY_SECOND)      st_d.ks = KS_OPEN;
                    else if (wdata == KEY_FIRST)  st_d.ks = KS_KEY1;
                    else                          st_d.ks = KS_LOCKED;
                end
            end
            KS_OPEN: begin
                if (idx_wr) begin
                    if (wdata == KEY_EXIT) st_d.ks = KS_LOCKED;
                    else                   idx_load = 1'b1;
                end
            end
            default: st_d.ks = KS_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ks: KS_LOCKED};
        else        st_q <= st_d;
    end

    assign open = (st_q.ks == KS_OPEN);

endmodule

// File: rtl/kcfg_bank.sv
module kcfg_bank
    import kcfg_pkg::*;
#(
    parameter int MODE_REGS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   wr,
    input  logic [7:0]             ofs,
    input  logic [7:0]             wdata,
    output logic                   rd_hit,
    output logic [7:0]             rd_val,
    output logic                   active,
    output logic [15:0]            base,
    output logic [7:0]             irq,
    output logic [7:0]             irq2,
    output logic [7:0]             dma,
    output logic [MODE_REGS*8-1:0] mode
);

    typedef struct packed {
        logic                        act;
        logic [15:0]                 base;
        logic [7:0]                  irq;
        logic [7:0]                  irq2;
        logic [7:0]                  dma;
        logic [MODE_REGS-1:0][7:0]   mode;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (wr) begin
            case (ofs)
                OFS_ACT:     st_d.act        = wdata[0];
                OFS_BASE_HI: st_d.base[15:8] = wdata;
                OFS_BASE_LO: st_d.base[7:0]  = wdata;
                OFS_IRQ:     st_d.irq        = wdata;
                OFS_IRQ2:    st_d.irq2       = wdata;
                OFS_DMA:     st_d.dma        = wdata;
                default: begin
                    for (int m = 0; m < MODE_REGS; m++) begin
                        if (ofs == OFS_MODE + 8'(m)) st_d.mode[m] = wdata;
                    end
                end
            endcase
        end
    end

    always_comb begin
        rd_hit = 1'b1;
        rd_val = RD_NONE;
        case (ofs)
            OFS_ACT:     rd_val = {7'd0, st_q.act};
            OFS_BASE_HI: rd_val = st_q.base[15:8];
            OFS_BASE_LO: rd_val = st_q.base[7:0];
            OFS_IRQ:     rd_val = st_q.irq;
            OFS_IRQ2:    rd_val = st_q.irq2;
            OFS_DMA:     rd_val = st_q.dma;
            default: begin
                rd_hit = 1'b0;
                for (int m = 0; m < MODE_REGS; m++) begin
                    if (ofs == OFS_MODE + 8'(m)) begin
                        rd_hit = 1'b1;
                        rd_val = st_q.mode[m];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.act;
    assign base   = st_q.base;
    assign irq    = st_q.irq;
    assign irq2   = st_q.irq2;
    assign dma    = st_q.dma;
    assign mode   = st_q.mode;

endmodule

// File: rtl/kcfg_port.sv
module kcfg_port
    import kcfg_pkg::*;
#(
    parameter int NUM_DEV   = 7,
    parameter int MODE_REGS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic                           addr,
    input  logic [7:0]                     wdata,
    output logic [7:0]                     rdata,
    output logic                           cfg_open,
    output logic [NUM_DEV-1:0]             dev_active,
    output logic [NUM_DEV*16-1:0]          dev_base,
    output logic [NUM_DEV*8-1:0]           dev_irq,
    output logic [NUM_DEV*8-1:0]           dev_irq2,
    output logic [NUM_DEV*8-1:0]           dev_dma,
    output logic [NUM_DEV*MODE_REGS*8-1:0] dev_mode,
    output logic [7:0]                     pd_direct,
    output logic [7:0]                     pd_auto
);

    localparam int MODE_W = MODE_REGS * 8;

    typedef struct packed {
        logic [7:0] index;
        logic [7:0] ldn;
        logic [7:0] pd_dir;
        logic [7:0] pd_auto;
    } glob_t;

    glob_t st_d, st_q;

    logic idx_wr, dat_wr, reg_wr, idx_load, open;
    logic bank_clr, bank_range;
    logic [7:0] cur_index;
    logic [NUM_DEV-1:0] sel, hit;
    logic [7:0] rd_val [NUM_DEV];

    assign idx_wr = wr_en & ~addr;
    assign dat_wr = wr_en & addr;

    kcfg_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .dat_wr   (dat_wr),
        .wdata    (wdata),
        .open     (open),
        .idx_load (idx_load)
    );

    assign cur_index  = st_q.index;
    assign reg_wr     = dat_wr & open;
    assign bank_range = (cur_index >= IDX_BANK_LO);
    assign bank_clr   = reg_wr & (cur_index == IDX_SRST) & wdata[0];

    genvar g;
    generate
        for (g = 0; g < NUM_DEV; g++) begin : g_bank
            assign sel[g] = (st_q.ldn == slot_ldn(g));

            kcfg_bank #(.MODE_REGS(MODE_REGS)) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (bank_clr),
                .wr     (reg_wr & bank_range & sel[g]),
                .ofs    (cur_index),
                .wdata  (wdata),
                .rd_hit (hit[g]),
                .rd_val (rd_val[g]),
                .active (dev_active[g]),
                .base   (dev_base[g*16 +: 16]),
                .irq    (dev_irq[g*8 +: 8]),
                .irq2   (dev_irq2[g*8 +: 8]),
                .dma    (dev_dma[g*8 +: 8]),
                .mode   (dev_mode[g*MODE_W +: MODE_W])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (idx_load) st_d.index = wdata;
        if (reg_wr) begin
            case (cur_index)
                IDX_LDN:     st_d.ldn     = wdata;
                IDX_PD_DIR:  st_d.pd_dir  = wdata;
                IDX_PD_AUTO: st_d.pd_auto = wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = RD_NONE;
        if (open) begin
            case (cur_index)
                IDX_SRST:    rdata = 8'h00;
                IDX_LDN:     rdata = st_q.ldn;
                IDX_PD_DIR:  rdata = st_q.pd_dir;
                IDX_PD_AUTO: rdata = st_q.pd_auto;
                default: begin
                    if (bank_range) begin
                        for (int s = 0; s < NUM_DEV; s++) begin
                            if (sel[s] && hit[s]) rdata = rd_val[s];
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_open  = open;
    assign pd_direct = st_q.pd_dir;
    assign pd_auto   = st_q.pd_auto;

endmodule

// File: rtl/kcfg_port_chk.sv
module kcfg_port_chk #(
    parameter int NUM_DEV   = 7,
    parameter int MODE_REGS = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           wr_en,
    input logic                           addr,
    input logic [7:0]                     wdata,
    input logic [7:0]                     rdata,
    input logic                           cfg_open,
    input logic [7:0]                     cur_index,
    input logic [NUM_DEV-1:0]             dev_active,
    input logic [NUM_DEV*16-1:0]          dev_base,
    input logic [NUM_DEV*8-1:0]           dev_irq,
    input logic [NUM_DEV*8-1:0]           dev_dma,
    input logic [NUM_DEV*MODE_REGS*8-1:0] dev_mode,
    input logic [7:0]                     pd_direct
);

    AST_LOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |-> rdata == 8'hFF); // R3

    AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(wr_en && !addr && wdata == 8'h23)); // R2

    AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && wr_en && !addr && wdata == 8'hBB) |=> !cfg_open); // R3

    AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> ($stable(dev_active) && $stable(dev_base) && $stable(dev_irq)
                       && $stable(dev_dma) && $stable(dev_mode) && $stable(pd_direct))); // R3

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && wr_en && addr && cur_index == 8'h02 && wdata[0])
        |=> (dev_active == '0 && dev_base == '0 && dev_mode == '0)); // R8

endmodule

bind kcfg_port kcfg_port_chk #(.NUM_DEV(NUM_DEV), .MODE_REGS(MODE_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .cfg_open   (cfg_open),
    .cur_index  (cur_index),
    .dev_active (dev_active),
    .dev_base   (dev_base),
    .dev_irq    (dev_irq),
    .dev_dma    (dev_dma),
    .dev_mode   (dev_mode),
    .pd_direct  (pd_direct)
);

// File: tb/test_kcfg_port.sv
module test_kcfg_port;

    localparam int ND = 7;
    localparam int NM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic cfg_open;
    logic [ND-1:0] dev_active;
    logic [ND*16-1:0] dev_base;
    logic [ND*8-1:0] dev_irq, dev_irq2, dev_dma;
    logic [ND*NM*8-1:0] dev_mode;
    logic [7:0] pd_direct, pd_auto;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    kcfg_port #(.NUM_DEV(ND), .MODE_REGS(NM)) i_kcfg_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cfg_open(cfg_open), .dev_active(dev_active),
        .dev_base(dev_base), .dev_irq(dev_irq), .dev_irq2(dev_irq2),
        .dev_dma(dev_dma), .dev_mode(dev_mode), .pd_direct(pd_direct),
        .pd_auto(pd_auto)
    );

    // reference model: 0 locked, 1 first key seen, 2 open
    int m_ks = 0;
    logic [7:0] m_idx = 0, m_ldn = 0, m_pdd = 0, m_pda = 0;
    logic [7:0] m_act [ND];
    logic [7:0] m_bhi [ND];
    logic [7:0] m_blo [ND];
    logic [7:0] m_irq [ND];
    logic [7:0] m_irq2[ND];
    logic [7:0] m_dma [ND];
    logic [7:0] m_mode[ND][NM];

    function automatic logic [7:0] ldn_of(int s);
        logic [7:0] t [7] = '{8'd0, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8};
        return t[s];
    endfunction

    function automatic int slot_of(logic [7:0] l);
        for (int s = 0; s < ND; s++) if (ldn_of(s) == l) return s;
        return -1;
    endfunction

    task automatic clear_banks();
        for (int s = 0; s < ND; s++) begin
            m_act[s] = 0; m_bhi[s] = 0; m_blo[s] = 0;
            m_irq[s] = 0; m_irq2[s] = 0; m_dma[s] = 0;
            for (int m = 0; m < NM; m++) m_mode[s][m] = 0;
        end
    endtask

    function automatic logic [7:0] model_rd();
        int s;
        if (m_ks != 2) return 8'hFF;
        case (m_idx)
            8'h02: return 8'h00;
            8'h07: return m_ldn;
            8'h22: return m_pdd;
            8'h23: return m_pda;
            default: ;
        endcase
        s = slot_of(m_ldn);
        if (s < 0) return 8'hFF;
        case (m_idx)
            8'h30: return m_act[s];
            8'h60: return m_bhi[s];
            8'h61: return m_blo[s];
            8'h70: return m_irq[s];
            8'h72: return m_irq2[s];
            8'h74: return m_dma[s];
            default: ;
        endcase
        for (int m = 0; m < NM; m++) if (m_idx == 8'hF0 + 8'(m)) return m_mode[s][m];
        return 8'hFF;
    endfunction

    task automatic model_wr(logic p, logic [7:0] b);
        int s;
        if (!p) begin
            case (m_ks)
                0: if (b == 8'h51) m_ks = 1;
                1: m_ks = (b == 8'h23) ? 2 : (b == 8'h51) ? 1 : 0;
                default: if (b == 8'hBB) m_ks = 0; else m_idx = b;
            endcase
        end else if (m_ks == 1) begin
            m_ks = 0;
        end else if (m_ks == 2) begin
            s = slot_of(m_ldn);
            case (m_idx)
                8'h02: if (b[0]) clear_banks();
                8'h07: m_ldn = b;
                8'h22: m_pdd = b;
                8'h23: m_pda = b;
                default: if (s >= 0) begin
                    case (m_idx)
                        8'h30: m_act[s] = {7'd0, b[0]};
                        8'h60: m_bhi[s] = b;
                        8'h61: m_blo[s] = b;
                        8'h70: m_irq[s] = b;
                        8'h72: m_irq2[s] = b;
                        8'h74: m_dma[s] = b;
                        default:
                            for (int m = 0; m < NM; m++)
                                if (m_idx == 8'hF0 + 8'(m)) m_mode[s][m] = b;
                    endcase
                end
            endcase
        end
    endtask

    task automatic wr(logic p, logic [7:0] b);
        wr_en = 1'b1; addr = p; wdata = b;
        @(posedge clk);
        model_wr(p, b);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check(req, "rdata", 128'(rdata), 128'(model_rd()));
        check(req, "open", 128'(cfg_open), 128'(m_ks == 2));
        check(req, "pd", 128'({pd_direct, pd_auto}), 128'({m_pdd, m_pda}));
        for (int s = 0; s < ND; s++) begin
            logic [NM*8-1:0] mexp;
            for (int m = 0; m < NM; m++) mexp[m*8 +: 8] = m_mode[s][m];
            check(req, "active", 128'(dev_active[s]), 128'(m_act[s][0]));
            check(req, "base", 128'(dev_base[s*16 +: 16]), 128'({m_bhi[s], m_blo[s]}));
            check(req, "irq", 128'({dev_irq[s*8 +: 8], dev_irq2[s*8 +: 8], dev_dma[s*8 +: 8]}),
                  128'({m_irq[s], m_irq2[s], m_dma[s]}));
            check(req, "mode", 128'(dev_mode[s*NM*8 +: NM*8]), 128'(mexp));
        end
    endtask

    task automatic unlock();
        wr(1'b0, 8'h51); wr(1'b0, 8'h23);
    endtask

    task automatic put(logic [7:0] idx, logic [7:0] val);
        wr(1'b0, idx); wr(1'b1, val);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] idx_set [14] = '{8'h02, 8'h07, 8'h22, 8'h23, 8'h30, 8'h60, 8'h61,
                                      8'h70, 8'h72, 8'h74, 8'hF0, 8'hF3, 8'hF4, 8'h10};
        void'($urandom(32'd1234));
        clear_banks();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R3: locked data writes do nothing
        wr(1'b1, 8'h5A);
        check_all("R3");

        // R2: broken keys, then repeated first byte
        wr(1'b0, 8'h51); wr(1'b0, 8'h24); wr(1'b0, 8'h23);
        check("R2", "wrong second byte", 128'(cfg_open), 128'(0));
        wr(1'b0, 8'h51); wr(1'b1, 8'h00); wr(1'b0, 8'h23);
        check("R2", "data write between", 128'(cfg_open), 128'(0));
        wr(1'b0, 8'h51); wr(1'b0, 8'h51); wr(1'b0, 8'h23);
        check("R2", "repeated first byte", 128'(cfg_open), 128'(1));

        // R4, R5: device 4 (slot 2)
        put(8'h07, 8'h04);
        check("R4", "ldn readback", 128'(rdata), 128'(8'h04));
        put(8'h30, 8'hFF); put(8'h60, 8'h03); put(8'h61, 8'hF8);
        put(8'h70, 8'h04); put(8'h72, 8'h0C); put(8'h74, 8'h02);
        check("R5", "base slot2", 128'(dev_base[2*16 +: 16]), 128'(16'h03F8));
        wr(1'b0, 8'h30);
        check("R5", "activate bit0 only", 128'(rdata), 128'(8'h01));
        check_all("R5");

        // R6, R10: mode bytes of device 8 (slot 6)
        put(8'h07, 8'h08);
        put(8'hF0, 8'hA1); put(8'hF3, 8'h3C);
        check("R6", "mode byte3", 128'(dev_mode[(6*NM+3)*8 +: 8]), 128'(8'h3C));
        check("R10", "other bank intact", 128'(dev_irq[2*8 +: 8]), 128'(8'h04));
        check_all("R10");

        // R7: unimplemented device and index
        put(8'h07, 8'h01);
        put(8'h70, 8'h09);
        check("R7", "unimpl dev read", 128'(rdata), 128'(8'hFF));
        wr(1'b0, 8'h10);
        check("R7", "unimpl index", 128'(rdata), 128'(8'hFF));
        check_all("R7");

        // R9: power control
        put(8'h22, 8'h5D); put(8'h23, 8'hC3);
        check("R9", "pd outputs", 128'({pd_direct, pd_auto}), 128'(16'h5DC3));
        wr(1'b0, 8'h22);
        check("R9", "pd readback", 128'(rdata), 128'(8'h5D));

        // R8: soft reset
        put(8'h02, 8'h00);
        check("R8", "bit0 clear no effect", 128'(dev_active[2]), 128'(1));
        put(8'h02, 8'h01);
        check("R8", "soft reset clears", 128'(dev_base[2*16 +: 16]), 128'(0));
        check("R8", "reg 02 reads 0", 128'(rdata), 128'(8'h00));
        check_all("R8");

        // R3: exit, writes ignored, reopen unchanged
        put(8'h07, 8'h05);
        put(8'h70, 8'h07);
        wr(1'b0, 8'hBB);
        check("R3", "exit locks", 128'(cfg_open), 128'(0));
        wr(1'b1, 8'h99);
        check_all("R3");
        unlock();
        check("R3", "locked write ignored", 128'(rdata), 128'(8'h07));

        // random mix
        for (int i = 0; i < 1500; i++) begin
            int r = int'($urandom_range(0, 99));
            if (r < 4)       wr(1'b0, 8'hBB);
            else if (r < 10) unlock();
            else if (r < 13) wr(1'b0, 8'h51);
            else if (r < 20) begin
                wr(1'b0, 8'h07);
                wr(1'b1, ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 10))
                                                     : ldn_of(int'($urandom_range(0, ND-1))));
            end else if (r < 55) wr(1'b0, idx_set[$urandom_range(0, 13)]);
            else begin
                logic [7:0] v = 8'($urandom);
                if (m_idx == 8'h02 && $urandom_range(0, 7) != 0) v[0] = 1'b0;
                wr(1'b1, v);
            end
            check_all("R5");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule